// File: doc/BRIEF.md
# Multiplexed 8-bit Bus Master

This block runs single register accesses to a peripheral over a narrow bus where the address and the data share the same lines. A local requester raises `req_valid` while the master is idle, with a read/write select, an address and, for writes, a data byte. The master then runs the bus sequence and answers with a one-cycle `rsp_done`. For reads, the byte it captured is on `rsp_rdata` in that same cycle.

Every access has a fixed shape. First the address is put on the shared lines while all three active-low strobes are high. Chip-select then falls, and the peripheral latches the address on that edge. No separate latch strobe exists. Next comes the data phase. For a write, the master replaces the address with the data and pulses write low. For a read, the master releases the lines and pulses read low, then samples the lines while read is still low. Each access closes in a set order: the strobe rises first, and chip-select rises one cycle later.

The pad register that holds the output value only updates bits whose value differs from the new target. Bits that do not need to change never toggle. While the lines are released, the register keeps its last value. The `WAIT_CYCLES` parameter lengthens the address, latch, setup and strobe phases by the same number of cycles.

Top module: `mux_bus_master`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pad_cs_n`, `pad_rd_n` and `pad_wr_n` are 1, `pad_oe` is 0, `rsp_done` is 0 and `req_ready` is 1.
- R2: In the cycle after a request is accepted, `pad_oe` is 1, `pad_out` holds `req_addr`, and all three strobes are 1. This address phase lasts 1+`WAIT_CYCLES` cycles.
- R3: Chip-select then falls while `pad_oe` stays 1 and `pad_out` still holds the address. This latch phase lasts 1+`WAIT_CYCLES` cycles. No other strobe moves.
- R4: On a write, `pad_out` then changes to the write data while `pad_cs_n`=0 and `pad_wr_n`=1, for 1+`WAIT_CYCLES` cycles. After that, `pad_wr_n` is 0 for 2+`WAIT_CYCLES` cycles. Write low only occurs while chip-select is low.
- R5: At the end of a write, `pad_wr_n` returns to 1 one cycle before `pad_cs_n` returns to 1.
- R6: On a read, `pad_oe` drops to 0 in the cycle after the latch phase, while read is still high, and stays 0 until the next access. `pad_rd_n` is then 0 for 2+`WAIT_CYCLES` cycles. `pad_oe` is never 1 while `pad_rd_n` is 0.
- R7: A read returns the value of `pad_in` from the last cycle in which `pad_rd_n` is 0. This value appears on `rsp_rdata` in the `rsp_done` cycle.
- R8: At the end of a read, `pad_rd_n` returns to 1 one cycle before `pad_cs_n` returns to 1.
- R9: Each accepted access gives exactly one `rsp_done` pulse, one cycle wide, in the cycle in which `pad_cs_n` first returns to 1. Counted from acceptance, this is 7+4×`WAIT_CYCLES` cycles.
- R10: `req_ready` is 1 only when the master is idle. A request raised while `req_ready` is 0 is ignored and starts no access.
- R11: `pad_out` only changes bits that differ from the next value to drive. While the lines are released, it keeps the last value driven, so after a read it still shows the address.
- R12: `WAIT_CYCLES` adds the same number of cycles to each of the address, latch, setup and strobe phases. The release cycle and the close cycle stay one cycle each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | BUS_W | Peripheral register address |
| req_wdata | input | BUS_W | Byte to write |
| req_ready | output | 1 | Master idle and able to take a request |
| rsp_rdata | output | BUS_W | Byte captured by the last read |
| rsp_done | output | 1 | One-cycle pulse when an access completes |
| pad_oe | output | 1 | Output enable for the shared lines |
| pad_out | output | BUS_W | Value driven on the shared lines |
| pad_in | input | BUS_W | Value seen on the shared lines |
| pad_cs_n | output | 1 | Chip-select, active low, also latches the address |
| pad_rd_n | output | 1 | Read strobe, active low |
| pad_wr_n | output | 1 | Write strobe, active low |

## Verification
The properties watch only the pad outputs and the response, so they make no assumption about `pad_in`. They do rely on `rst` being held high from time zero until the first clock edges, so that no strobe edge is seen before the state is known. The stimulus changes request inputs only on the falling clock edge. It raises `req_valid` for a single cycle, apart from one deliberate pulse sent while busy. A small peripheral model in the bench latches the address on the falling edge of chip-select and stores data on the rising edge of write. It drives `pad_in` only while read is low, which matches the bus discipline the properties expect.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LATCH,
        ST_SETUP,
        ST_STROBE,
        ST_RELEASE,
        ST_CLOSE
    } mbm_state_e;

    typedef struct packed {
        logic cs_n;
        logic rd_n;
        logic wr_n;
        logic oe;
        logic sel_wdata;
    } mbm_pins_t;

    localparam mbm_pins_t PINS_RESET = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                         oe: 1'b0, sel_wdata: 1'b0};

    // Number of cycles spent in a phase
    function automatic int unsigned phase_len(mbm_state_e s, int unsigned waits);
        case (s)
            ST_ADDR, ST_LATCH, ST_SETUP: return 1 + waits;
            ST_STROBE:                   return 2 + waits;
            default:                     return 1;
        endcase
    endfunction

    // Pin levels for a phase; is_wr selects write or read behaviour
    function automatic mbm_pins_t pins_for(mbm_state_e s, logic is_wr);
        mbm_pins_t p;
        p = PINS_RESET;
        case (s)
            ST_ADDR: begin
                p.oe = 1'b1;
            end
            ST_LATCH: begin
                p.cs_n = 1'b0;
                p.oe   = 1'b1;
            end
            ST_SETUP, ST_RELEASE: begin
                p.cs_n      = 1'b0;
                p.oe        = is_wr;
                p.sel_wdata = 1'b1;
            end
            ST_STROBE: begin
                p.cs_n      = 1'b0;
                p.rd_n      = is_wr;
                p.wr_n      = ~is_wr;
                p.oe        = is_wr;
                p.sel_wdata = 1'b1;
            end
            ST_CLOSE: begin
                p.oe        = is_wr;
                p.sel_wdata = 1'b1;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mbm_seq.sv
module mbm_seq
    import mbm_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  logic      req_write,
    output logic      accept,
    output logic      idle,
    output mbm_pins_t pins_next,
    output mbm_pins_t pins_q,
    output logic      sample_en,
    output logic      done
);
    localparam int unsigned CW = $clog2(WAIT_CYCLES + 3);

    mbm_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          wr_q, wr_d, last;

    assign idle   = (st_q == ST_IDLE);
    assign accept = idle && req_valid;
    assign last   = (cnt_q == '0);
    assign wr_d   = accept ? req_write : wr_q;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:    if (accept) st_d = ST_ADDR;
            ST_ADDR:    if (last)   st_d = ST_LATCH;
            ST_LATCH:   if (last)   st_d = ST_SETUP;
            ST_SETUP:   if (last)   st_d = ST_STROBE;
            ST_STROBE:  if (last)   st_d = ST_RELEASE;
            ST_RELEASE:             st_d = ST_CLOSE;
            ST_CLOSE:               st_d = ST_IDLE;
            default:                st_d = ST_IDLE;
        endcase
    end

    assign pins_next = pins_for(st_d, wr_d);
    assign sample_en = (st_q == ST_STROBE) && last && !wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            wr_q   <= 1'b0;
            pins_q <= PINS_RESET;
            done   <= 1'b0;
        end else begin
            st_q   <= st_d;
            wr_q   <= wr_d;
            pins_q <= pins_next;
            done   <= (st_d == ST_CLOSE);
            if (st_d != st_q)
                cnt_q <= CW'(phase_len(st_d, WAIT_CYCLES) - 1);
            else if (!last)
                cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/mbm_req_hold.sv
module mbm_req_hold #(
    parameter int unsigned BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [BUS_W-1:0] addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] addr_q,
    output logic [BUS_W-1:0] wdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (capture) begin
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end
endmodule

// File: rtl/mbm_pad_drv.sv
module mbm_pad_drv #(
    parameter int unsigned BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [BUS_W-1:0] target,
    output logic [BUS_W-1:0] value
);
    // Each bit has its own enable; it flips only when it differs from target
    for (genvar b = 0; b < BUS_W; b++) begin : g_bit
        logic flip;
        assign flip = load && (value[b] != target[b]);
        always_ff @(posedge clk) begin
            if (rst)
                value[b] <= 1'b0;
            else if (flip)
                value[b] <= ~value[b];
        end
    end
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
    import mbm_pkg::*;
#(
    parameter int unsigned BUS_W       = 8,
    parameter int unsigned WAIT_CYCLES = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    output logic             req_ready,
    output logic [BUS_W-1:0] rsp_rdata,
    output logic             rsp_done,
    output logic             pad_oe,
    output logic [BUS_W-1:0] pad_out,
    input  logic [BUS_W-1:0] pad_in,
    output logic             pad_cs_n,
    output logic             pad_rd_n,
    output logic             pad_wr_n
);
    mbm_pins_t        pins_next, pins_q;
    logic             accept, idle, sample_en;
    logic [BUS_W-1:0] addr_q, wdata_q, target, rdata_q;

    mbm_seq #(.WAIT_CYCLES(WAIT_CYCLES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .accept    (accept),
        .idle      (idle),
        .pins_next (pins_next),
        .pins_q    (pins_q),
        .sample_en (sample_en),
        .done      (rsp_done)
    );

    mbm_req_hold #(.BUS_W(BUS_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .capture (accept),
        .addr    (req_addr),
        .wdata   (req_wdata),
        .addr_q  (addr_q),
        .wdata_q (wdata_q)
    );

    // Address comes straight from the request in the first driven cycle
    assign target = accept ? req_addr : (pins_next.sel_wdata ? wdata_q : addr_q);

    mbm_pad_drv #(.BUS_W(BUS_W)) u_pad (
        .clk    (clk),
        .rst    (rst),
        .load   (pins_next.oe),
        .target (target),
        .value  (pad_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (sample_en)
            rdata_q <= pad_in;
    end

    assign req_ready = idle;
    assign rsp_rdata = rdata_q;
    assign pad_oe    = pins_q.oe;
    assign pad_cs_n  = pins_q.cs_n;
    assign pad_rd_n  = pins_q.rd_n;
    assign pad_wr_n  = pins_q.wr_n;
endmodule

// File: rtl/mux_bus_master_chk.sv
module mux_bus_master_chk #(
    parameter int unsigned BUS_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             rsp_done,
    input logic             pad_oe,
    input logic [BUS_W-1:0] pad_out,
    input logic             pad_cs_n,
    input logic             pad_rd_n,
    input logic             pad_wr_n
);
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> (pad_cs_n && pad_rd_n && pad_wr_n && !pad_oe && req_ready));

    a_r2_addr_before_cs: assert property (@(posedge clk) disable iff (rst)
        $fell(pad_cs_n) |-> ($past(pad_oe) && $past(pad_rd_n) && $past(pad_wr_n)));

    a_r3_addr_stable_at_cs_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(pad_cs_n) |-> (pad_oe && $stable(pad_out)));

    a_r4_wr_within_cs: assert property (@(posedge clk) disable iff (rst)
        !pad_wr_n |-> (!pad_cs_n && pad_oe));

    a_r4_wr_min_two: assert property (@(posedge clk) disable iff (rst)
        $fell(pad_wr_n) |=> !pad_wr_n);

    a_r5_strobes_rise_first: assert property (@(posedge clk) disable iff (rst)
        $rose(pad_cs_n) |-> ($past(pad_wr_n) && $past(pad_rd_n)));

    a_r6_no_drive_in_read: assert property (@(posedge clk) disable iff (rst)
        !pad_rd_n |-> (!pad_oe && !pad_cs_n));

    a_r6_release_before_rd: assert property (@(posedge clk) disable iff (rst)
        $fell(pad_rd_n) |-> !$past(pad_oe));

    a_r8_rd_min_two: assert property (@(posedge clk) disable iff (rst)
        $fell(pad_rd_n) |=> !pad_rd_n);

    a_r9_done_at_cs_rise: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $rose(pad_cs_n));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    a_r10_ready_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (pad_cs_n && pad_rd_n && pad_wr_n));

    a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(~pad_rd_n && ~pad_wr_n));
endmodule

bind mux_bus_master mux_bus_master_chk #(.BUS_W(BUS_W)) chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_cs_n  (pad_cs_n),
    .pad_rd_n  (pad_rd_n),
    .pad_wr_n  (pad_wr_n)
);

// File: tb/mux_bus_master_test.sv
module mux_bus_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int MAX_CYCLES = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0, req_valid_s = 1'b0, req_write = 1'b0;
    logic [W-1:0] req_addr = '0, req_wdata = '0;
    logic         req_ready, rsp_done, pad_oe, pad_cs_n, pad_rd_n, pad_wr_n;
    logic [W-1:0] rsp_rdata, pad_out, pad_in;
    logic         s_ready, s_done, s_oe, s_cs_n, s_rd_n, s_wr_n;
    logic [W-1:0] s_rdata, s_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_master #(.BUS_W(W)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_in(pad_in), .pad_cs_n(pad_cs_n),
        .pad_rd_n(pad_rd_n), .pad_wr_n(pad_wr_n)
    );

    mux_bus_master #(.BUS_W(W), .WAIT_CYCLES(2)) uut_slow (
        .clk(clk), .rst(rst), .req_valid(req_valid_s), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(s_ready),
        .rsp_rdata(s_rdata), .rsp_done(s_done), .pad_oe(s_oe),
        .pad_out(s_out), .pad_in(pad_in), .pad_cs_n(s_cs_n),
        .pad_rd_n(s_rd_n), .pad_wr_n(s_wr_n)
    );

    // Peripheral model: address latched on chip-select fall, data stored on write rise
    logic [W-1:0] mem [256];
    logic [W-1:0] lat = '0;
    always @(negedge pad_cs_n) lat = pad_out;
    always @(posedge pad_wr_n) if (pad_cs_n === 1'b0) mem[lat] = pad_out;
    assign pad_in = (pad_rd_n === 1'b0) ? mem[lat] : '0;

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > MAX_CYCLES) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected <= %0d cycles", cycles, MAX_CYCLES);
            finish_run();
        end
    end

    // {cs_n, rd_n, wr_n, oe, done, out}
    function automatic logic [12:0] expect_vec(int i, bit wr, logic [W-1:0] a, logic [W-1:0] d);
        logic cs, rd, wn, oe, dn;
        logic [W-1:0] o;
        cs = !(i >= 2 && i <= 6);
        rd = wr ? 1'b1 : !(i == 4 || i == 5);
        wn = wr ? !(i == 4 || i == 5) : 1'b1;
        oe = wr ? 1'b1 : (i <= 2);
        dn = (i == 7);
        o  = (wr && i >= 3) ? d : a;
        return {cs, rd, wn, oe, dn, o};
    endfunction

    function automatic string tag_for(int i, bit wr);
        case (i)
            1: return "R2 addr phase";
            2: return "R3 cs latch";
            3: return wr ? "R4 data setup" : "R6 release";
            4, 5: return wr ? "R4 wr low" : "R6 rd low";
            6: return wr ? "R5 wr rises first" : "R8 rd rises first";
            default: return "R9 done with cs rise, R11 hold";
        endcase
    endfunction

    task automatic run_access(bit wr, logic [W-1:0] a, logic [W-1:0] d, bit poke_busy);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        for (int i = 1; i <= 7; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (poke_busy && i == 3) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 8'hFF; req_wdata = 8'h5A;
                check("R10 busy ready low", {31'b0, req_ready}, 32'd0);
            end
            check(tag_for(i, wr), {19'b0, pad_cs_n, pad_rd_n, pad_wr_n, pad_oe, rsp_done, pad_out},
                  {19'b0, expect_vec(i, wr, a, d)});
            if (!wr && i == 7)
                check("R7 read data", {24'b0, rsp_rdata}, {24'b0, mem[a]});
        end
    endtask

    task automatic test_reset();
        check("R1 reset pins", {28'b0, pad_cs_n, pad_rd_n, pad_wr_n, pad_oe}, {28'b0, 4'b1110});
        check("R1 reset ready/done", {30'b0, req_ready, rsp_done}, {30'b0, 2'b10});
    endtask

    task automatic test_write_read();
        run_access(1'b1, 8'h3C, 8'hA5, 1'b0);
        check("R4 model stored", {24'b0, mem[8'h3C]}, {24'b0, 8'hA5});
        run_access(1'b1, 8'hC3, 8'h0F, 1'b0);
        run_access(1'b0, 8'h3C, 8'h00, 1'b0);
        run_access(1'b0, 8'hC3, 8'h00, 1'b0);
        check("R11 hold after read", {24'b0, pad_out}, {24'b0, 8'hC3});
        run_access(1'b1, 8'h00, 8'hFF, 1'b0);
        run_access(1'b0, 8'h00, 8'h00, 1'b0);
    endtask

    task automatic test_busy_ignored();
        mem[8'h9A] = 8'h11;
        mem[8'h65] = 8'h22;
        run_access(1'b1, 8'h9A, 8'h77, 1'b1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R10 no extra access", {30'b0, pad_cs_n, rsp_done}, {30'b0, 2'b10});
        end
        check("R10 target untouched", {24'b0, mem[8'h65]}, {24'b0, 8'h22});
        check("R10 real write done", {24'b0, mem[8'h9A]}, {24'b0, 8'h77});
    endtask

    task automatic test_wait_states();
        int total = 0, wr_low = 0, cs_low = 0, addr_only = 0;
        @(negedge clk);
        req_valid_s = 1'b1; req_write = 1'b1; req_addr = 8'h44; req_wdata = 8'h99;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            req_valid_s = 1'b0;
            if (total == 0) begin
                if (!s_wr_n) wr_low++;
                if (!s_cs_n) cs_low++;
                if (s_oe && s_cs_n && s_out == 8'h44) addr_only++;
                if (s_done) total = i;
            end
        end
        check("R12 latency 7+4W", total, 15);
        check("R12 wr low 2+W", wr_low, 4);
        check("R12 addr phase 1+W", addr_only, 3);
        check("R12 cs low span", cs_low, 11);
    endtask

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 8'(k * 7 + 1);
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_write_read();
        test_busy_ignored();
        test_wait_states();
        finish_run();
    end
endmodule